// File: doc/BRIEF.md
# Command Microcontroller ALU with Ordered Compare Code

This block is the arithmetic and logic unit of a small register-based command processor. In one combinational pass it turns an operation code, a first operand and a second operand into a 32-bit result. The second operand is either a register value or a zero-extended 16-bit immediate. A single flag register keeps the carry or borrow of the last arithmetic operation. A later high-half add or subtract uses that flag, so firmware can work on 64-bit quantities as two 32-bit halves.

The compare operation does not give a boolean. It gives one of three small constants, and their bit patterns let a single-bit branch test express greater-than, greater-or-equal, less-than or less-or-equal. A move-immediate operation shifts the immediate left by a given amount, so one instruction can load an upper half or place a small bitfield. There is also a byte multiply that produces a 16-bit product.

The instruction decoder drives the operation code and operand selection. The result goes back to the register file. The carry flag is the only state inside the block.

Top module: `mcu_alu`

## Requirements
- R1: The second operand is `{16'b0, imm_i}` when `use_imm_i` is 1 and `src2_i` otherwise. Opcodes on `op_i`: 0 add, 1 add-high, 2 sub, 3 sub-high, 4 and, 5 or, 6 xor, 7 not, 8 shift-left, 9 logical shift-right, 10 arithmetic shift-right, 11 rotate-left, 12 byte multiply, 13 min, 14 max, 15 compare, 16 move-immediate. The codes 17 to 31 give a result of 0.
- R2: Add returns `src1 + op2` modulo 2^32. Sub returns `src1 - op2` modulo 2^32. After the next rising clock edge, `carry_o` holds the carry-out of the add, or holds 1 if the sub borrowed (src1 < op2 unsigned).
- R3: Add-high returns `src1 + op2 + carry_o`. Sub-high returns `src1 - op2 - carry_o`. Each one updates `carry_o` at the next edge with its own carry-out, or with its borrow (set when src1 < op2 + carry_o).
- R4: `carry_o` is 0 after reset. It keeps its value across every operation other than the four arithmetic ones.
- R5: And, or and xor combine src1 with op2 bitwise. Not returns `~op2` and ignores src1.
- R6: Shift-left, logical shift-right and arithmetic shift-right (sign-filling) act on src1. The amount is op2[4:0], and the higher bits of op2 are ignored.
- R7: Rotate-left moves src1 left by op2[4:0], and the bits that leave the top come back in at the bottom.
- R8: Byte multiply returns the unsigned product of src1[7:0] and op2[7:0], zero-extended to 32 bits.
- R9: Min and max return the smaller and the larger operand, compared as unsigned values.
- R10: Compare, treating both operands as unsigned, returns 0x00 when src1 > op2, 0x2b when src1 == op2 and 0x1e when src1 < op2.
- R11: Move-immediate returns `{16'b0, imm_i} << imm_shift_i`, truncated to 32 bits. It ignores both src1 and src2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the carry flag |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| src1_i | input | 32 | First operand |
| src2_i | input | 32 | Second operand, register form |
| imm_i | input | 16 | Immediate value |
| use_imm_i | input | 1 | Selects the immediate as the second operand |
| imm_shift_i | input | 5 | Left shift applied by move-immediate |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Registered carry or borrow flag |

## Verification
The hardest cases to reach are the ones where the carry decides a high-half result. Examples are a sub-high with equal operands and an incoming borrow, or an add-high whose only carry comes from the flag. Uniform random operands almost never produce these. The directed sequences therefore build 64-bit chains with all-ones and all-zero halves and put non-arithmetic operations between the two halves, which shows that the flag holds its value. Equal operands for compare, min and max are forced by copying one random operand into the other.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDHI = 5'd1,  OP_SUB  = 5'd2,  OP_SUBHI = 5'd3,
    OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR  = 5'd6,  OP_NOT   = 5'd7,
    OP_SHL   = 5'd8,  OP_USHR  = 5'd9,  OP_ISHR = 5'd10, OP_ROT   = 5'd11,
    OP_MUL8  = 5'd12, OP_MIN   = 5'd13, OP_MAX  = 5'd14, OP_CMP   = 5'd15,
    OP_MOVI  = 5'd16
  } alu_op_e;

  localparam logic [7:0] CMP_GT = 8'h00;
  localparam logic [7:0] CMP_EQ = 8'h2b;
  localparam logic [7:0] CMP_LT = 8'h1e;
endpackage

// File: rtl/mcu_alu_addsub.sv
module mcu_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic              sub_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  logic [DATA_W:0] wide;
  logic            ci;

  assign ci = hi_i & cin_i;

  always_comb begin
    if (sub_i) wide = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, ci};
    else       wide = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, ci};
  end

  // top bit is carry for add, borrow for sub
  assign sum_o  = wide[DATA_W-1:0];
  assign cout_o = wide[DATA_W];
endmodule

// File: rtl/mcu_alu_shift.sv
module mcu_alu_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  mcu_alu_pkg::alu_op_e op_i,
  input  logic [DATA_W-1:0]    a_i,
  input  logic [SH_W-1:0]      amt_i,
  output logic [DATA_W-1:0]    res_o
);
  import mcu_alu_pkg::*;
  logic [2*DATA_W-1:0] dbl;

  assign dbl = {a_i, a_i} << amt_i;

  always_comb begin
    unique case (op_i)
      OP_SHL:  res_o = a_i << amt_i;
      OP_USHR: res_o = a_i >> amt_i;
      OP_ISHR: res_o = DATA_W'($signed(a_i) >>> amt_i);
      OP_ROT:  res_o = dbl[2*DATA_W-1:DATA_W];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/mcu_alu_order.sv
module mcu_alu_order #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] cmp_o
);
  import mcu_alu_pkg::*;
  logic lt, eq;

  assign lt    = a_i < b_i;
  assign eq    = a_i == b_i;
  assign min_o = lt ? a_i : b_i;
  assign max_o = lt ? b_i : a_i;
  assign cmp_o = DATA_W'(eq ? CMP_EQ : (lt ? CMP_LT : CMP_GT));
endmodule

// File: rtl/mcu_alu.sv
module mcu_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int MUL_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [SH_W-1:0]   imm_shift_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  import mcu_alu_pkg::*;

  alu_op_e           op;
  logic [DATA_W-1:0] op2, imm_ext;
  logic [DATA_W-1:0] as_res, sh_res, min_res, max_res, cmp_res, mul_res;
  logic              as_cout, is_arith, carry_q;

  assign op       = alu_op_e'(op_i);
  assign imm_ext  = {{(DATA_W-IMM_W){1'b0}}, imm_i};
  assign op2      = use_imm_i ? imm_ext : src2_i;
  assign is_arith = (op == OP_ADD) || (op == OP_ADDHI) || (op == OP_SUB) || (op == OP_SUBHI);
  assign mul_res  = DATA_W'(src1_i[MUL_W-1:0] * op2[MUL_W-1:0]);

  mcu_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .sub_i (op == OP_SUB || op == OP_SUBHI),
    .hi_i  (op == OP_ADDHI || op == OP_SUBHI),
    .a_i   (src1_i),
    .b_i   (op2),
    .cin_i (carry_q),
    .sum_o (as_res),
    .cout_o(as_cout)
  );

  mcu_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .op_i (op),
    .a_i  (src1_i),
    .amt_i(op2[SH_W-1:0]),
    .res_o(sh_res)
  );

  mcu_alu_order #(.DATA_W(DATA_W)) u_order (
    .a_i  (src1_i),
    .b_i  (op2),
    .min_o(min_res),
    .max_o(max_res),
    .cmp_o(cmp_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADDHI, OP_SUB, OP_SUBHI: result_o = as_res;
      OP_AND:  result_o = src1_i & op2;
      OP_OR:   result_o = src1_i | op2;
      OP_XOR:  result_o = src1_i ^ op2;
      OP_NOT:  result_o = ~op2;
      OP_SHL, OP_USHR, OP_ISHR, OP_ROT: result_o = sh_res;
      OP_MUL8: result_o = mul_res;
      OP_MIN:  result_o = min_res;
      OP_MAX:  result_o = max_res;
      OP_CMP:  result_o = cmp_res;
      OP_MOVI: result_o = imm_ext << imm_shift_i;
      default: result_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       carry_q <= 1'b0;
    else if (is_arith) carry_q <= as_cout;
  end

  assign carry_o = carry_q;

  assert_carry_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_arith |=> $stable(carry_q));

  assert_cmp_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_CMP |-> (result_o == DATA_W'(CMP_GT) || result_o == DATA_W'(CMP_EQ)
                      || result_o == DATA_W'(CMP_LT)));

  assert_min_le_max_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_MIN |-> (min_res <= max_res && (result_o == src1_i || result_o == op2)));

  assert_mul_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_MUL8 |-> result_o[DATA_W-1:2*MUL_W] == '0);

  assert_add_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_ADD |=> carry_q == ({1'b0, $past(result_o)} < {1'b0, $past(src1_i)}));
endmodule

// File: tb/mcu_alu_tb_top.sv
`timescale 1ns/1ps
module mcu_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op_i = '0;
  logic [31:0] src1_i = '0, src2_i = '0;
  logic [15:0] imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [4:0]  imm_shift_i = '0;
  logic [31:0] result_o;
  logic        carry_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic mcarry = 1'b0;

  always #10 clk_i = ~clk_i;

  mcu_alu dut_i (.*);

  function automatic string req_of(int op);
    case (op)
      0, 2: return "R2";  1, 3: return "R3";
      4, 5, 6, 7: return "R5";  8, 9, 10: return "R6";
      11: return "R7";  12: return "R8";  13, 14: return "R9";
      15: return "R10"; 16: return "R11"; default: return "R1";
    endcase
  endfunction

  // returns {next_carry, result}
  function automatic logic [32:0] ref_op(int op, logic [31:0] a, logic [31:0] b,
                                         logic [15:0] im, logic [4:0] ish, logic c);
    logic [32:0] w;
    logic [31:0] r;
    int sh;
    sh = int'(b[4:0]);
    case (op)
      0: begin w = {1'b0, a} + {1'b0, b}; return w; end
      1: begin w = {1'b0, a} + {1'b0, b} + {32'd0, c}; return w; end
      2: return {a < b, a - b};
      3: return {(a < b) || (a == b && c), a - b - {31'd0, c}};
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~b;
      8: r = a << sh;
      9: r = a >> sh;
      10: begin r = a; for (int i = 0; i < sh; i++) r = {r[31], r[31:1]}; end
      11: begin r = a; for (int i = 0; i < sh; i++) r = {r[30:0], r[31]}; end
      12: r = {16'd0, 16'(a[7:0]) * 16'(b[7:0])};
      13: r = (a < b) ? a : b;
      14: r = (a > b) ? a : b;
      15: r = (a > b) ? 32'h00 : ((a == b) ? 32'h2b : 32'h1e);
      16: r = {16'd0, im} << ish;
      default: r = '0;
    endcase
    return {c, r};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(int op, logic [31:0] a, logic [31:0] b, logic [15:0] im,
                       logic ui, logic [4:0] ish);
    logic [32:0] e;
    logic [31:0] b_eff;
    @(negedge clk_i);
    op_i = 5'(op); src1_i = a; src2_i = b; imm_i = im; use_imm_i = ui; imm_shift_i = ish;
    #5;
    b_eff = ui ? {16'd0, im} : b;
    e = ref_op(op, a, b_eff, im, ish, mcarry);
    check(req_of(op), "result", result_o, e[31:0]);
    check((op <= 3) ? req_of(op) : "R4", "carry", {31'd0, carry_o}, {31'd0, mcarry});
    @(posedge clk_i);
    mcarry = e[32];
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    #1;
    check("R4", "reset carry", {31'd0, carry_o}, 32'd0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2 R3: 64-bit add chain all-ones + 1, with unrelated ops in between (R4)
    do_op(0, 32'hffff_ffff, 32'd1, 16'd0, 0, 0);
    do_op(4, 32'h1234, 32'h00ff, 16'd0, 0, 0);
    do_op(15, 32'd5, 32'd5, 16'd0, 0, 0);
    do_op(1, 32'hffff_ffff, 32'd0, 16'd0, 0, 0);
    // R3: sub-high with equal operands and incoming borrow
    do_op(2, 32'd0, 32'd1, 16'd0, 0, 0);
    do_op(3, 32'h8000_0000, 32'h8000_0000, 16'd0, 0, 0);
    do_op(3, 32'd7, 32'd3, 16'd0, 0, 0);
    // R10 orderings, including across the sign bit
    do_op(15, 32'h8000_0000, 32'd1, 16'd0, 0, 0);
    do_op(15, 32'd1, 32'h8000_0000, 16'd0, 0, 0);
    do_op(15, 32'd3, 32'd0, 16'd3, 1, 0);
    // R9 unsigned min/max
    do_op(13, 32'hffff_fff0, 32'd2, 16'd0, 0, 0);
    do_op(14, 32'hffff_fff0, 32'd2, 16'd0, 0, 0);
    // R6 R7 boundaries, upper amount bits ignored
    do_op(10, 32'h8000_0001, 32'hffff_ffe4, 16'd0, 0, 0);
    do_op(11, 32'h8000_0001, 32'd31, 16'd0, 0, 0);
    do_op(8, 32'h0000_0003, 32'd0, 16'd0, 0, 0);
    // R8 high byte bits ignored
    do_op(12, 32'hffff_ffff, 32'h1234_56ff, 16'd0, 0, 0);
    // R5 not with immediate ignores src1
    do_op(7, 32'hdead_beef, 32'd0, 16'h00f0, 1, 0);
    // R11 load upper half, ignore sources
    do_op(16, 32'hffff_ffff, 32'hffff_ffff, 16'habcd, 0, 5'd16);
    do_op(16, 32'd0, 32'd0, 16'hffff, 1, 5'd31);
    // R1 unused codes
    do_op(17, 32'h1, 32'h2, 16'd0, 0, 0);
    do_op(31, 32'hffff_ffff, 32'h2, 16'd0, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      int op;
      logic [31:0] a, b;
      op = int'($urandom_range(0, 18));
      a = $urandom; b = $urandom;
      if ($urandom_range(0, 7) == 0) b = a;
      if ($urandom_range(0, 7) == 0) a = 32'hffff_ffff;
      do_op(op, a, b, 16'($urandom), 1'($urandom), 5'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule